// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block holds the hazard-resolution decisions for a five-stage in-order integer pipeline: fetch, decode, execute, memory and writeback. It is fully combinational. For every cycle it looks at the register fields and flags of the instructions in decode, execute, memory and writeback. From these it decides four things: where each execute operand comes from, whether fetch and decode must hold, whether a bubble goes into execute, and whether the fetch/decode register must be squashed.

Branches are compared in decode, so a taken branch has fetched only one wrong-path instruction. A mode input selects between two architectural rules. In interlock mode, load-use and branch-operand hazards are covered by hardware stalls, and a taken branch costs one bubble. In slot mode, the instruction after a load and the instruction after a branch are architectural delay slots. The block then never stalls or squashes, and a load-slot consumer sees the old register value. A register written back in the same cycle is visible in decode, because the register file writes first and reads second, so writeback never needs a path into decode.

Top module: `hazard_ctrl`

## Requirements
- R1: An execute operand whose register matches a register-writing, non-load instruction in memory gets select code 2'b10.
- R2: If no memory match applies and a writing instruction in writeback matches, the select code is 2'b01. Otherwise it is 2'b00, meaning the register file.
- R3: When memory and writeback both write the operand's register, memory wins and the code is 2'b10.
- R4: Register 0 never produces a non-zero forwarding select, never stalls and never forwards into decode.
- R5: In interlock mode (slot_mode=0), a decode instruction reading a used source register written by a load in execute raises stall_fetch, stall_decode and bubble_ex together.
- R6: A load in execute whose destination is not among the used decode sources causes no stall.
- R7: In interlock mode, a branch in decode stalls when a used source is written by any writing instruction in execute, or by a load in memory.
- R8: A decode source matching a writing, non-load instruction in memory sets its decode-compare forward bit (dec_fwd_a for rs, dec_fwd_b for rt).
- R9: In interlock mode, a taken branch in decode that is not stalled raises flush_fd. A not-taken or stalled branch does not.
- R10: In slot mode (slot_mode=1), stall_fetch, stall_decode, bubble_ex and flush_fd stay low for every input.
- R11: A load in memory is never forwarded into execute, so the operand falls back to writeback (2'b01) or the register file (2'b00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| slot_mode | input | 1 | 0: interlocked stalls and branch squash; 1: architectural delay slots |
| id_rs | input | REG_W | Decode first source register |
| id_rt | input | REG_W | Decode second source register |
| id_rs_used | input | 1 | Decode instruction reads id_rs |
| id_rt_used | input | 1 | Decode instruction reads id_rt |
| id_branch | input | 1 | Decode holds a conditional branch |
| id_taken | input | 1 | Decode comparator says the branch is taken |
| ex_rs | input | REG_W | Execute first source register |
| ex_rt | input | REG_W | Execute second source register |
| ex_rd | input | REG_W | Execute destination register |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | REG_W | Memory-stage destination register |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | REG_W | Writeback destination register |
| wb_wen | input | 1 | Writeback instruction writes a register |
| fwd_a | output | 2 | Execute operand A source select |
| fwd_b | output | 2 | Execute operand B source select |
| dec_fwd_a | output | 1 | Decode comparator operand A from memory stage |
| dec_fwd_b | output | 1 | Decode comparator operand B from memory stage |
| stall_fetch | output | 1 | Hold the program counter |
| stall_decode | output | 1 | Hold the fetch/decode register |
| bubble_ex | output | 1 | Load a no-op into execute |
| flush_fd | output | 1 | Squash the fetch/decode register into a no-op |

## Verification
The hardest situation to reach is a branch in decode that has a load one stage ahead in memory, while a different producer sits in execute. Stall, flush and decode forwarding then all depend on which producer matches. The stimulus sweeps every combination of branch source, execute and memory destinations, write and load flags, taken flag and mode over a four-register space. It compares each output against an arithmetic restatement. Separate sweeps cover the execute forwarding priority and the load-use interlock across both modes and both source-use flags.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_WB  = 2'b01,
    SRC_MEM = 2'b10
  } src_sel_e;
endpackage

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_wen,
  input  logic             mem_load,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_wen,
  output logic [1:0]       sel
);
  import hz_pkg::*;

  function automatic logic produces(input logic [REG_W-1:0] s,
                                    input logic [REG_W-1:0] d,
                                    input logic             w);
    return w && (d != '0) && (d == s);
  endfunction

  logic mem_hit, wb_hit;
  assign mem_hit = produces(src, mem_rd, mem_wen) && !mem_load;
  assign wb_hit  = produces(src, wb_rd, wb_wen);

  always_comb begin
    if (mem_hit)     sel = SRC_MEM;
    else if (wb_hit) sel = SRC_WB;
    else             sel = SRC_RF;
  end
endmodule

// File: rtl/hz_stall_unit.sv
module hz_stall_unit #(
  parameter int REG_W = 5
) (
  input  logic             slot_mode,
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic             id_rs_used,
  input  logic             id_rt_used,
  input  logic             id_branch,
  input  logic             id_taken,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_wen,
  input  logic             ex_load,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_wen,
  input  logic             mem_load,
  output logic             load_use,
  output logic             br_wait,
  output logic             stall,
  output logic             flush
);
  function automatic logic reads(input logic [REG_W-1:0] d,
                                 input logic [REG_W-1:0] a, input logic ua,
                                 input logic [REG_W-1:0] b, input logic ub);
    return (d != '0) && ((ua && a == d) || (ub && b == d));
  endfunction

  logic interlock, ex_dep, mem_dep;
  assign interlock = !slot_mode;
  assign ex_dep    = ex_wen  && reads(ex_rd,  id_rs, id_rs_used, id_rt, id_rt_used);
  assign mem_dep   = mem_wen && reads(mem_rd, id_rs, id_rs_used, id_rt, id_rt_used);

  assign load_use = interlock && ex_load && ex_dep;
  assign br_wait  = interlock && id_branch && (ex_dep || (mem_load && mem_dep));
  assign stall    = load_use || br_wait;
  assign flush    = interlock && id_branch && id_taken && !stall;
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl #(
  parameter int REG_W = 5
) (
  input  logic             slot_mode,
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic             id_rs_used,
  input  logic             id_rt_used,
  input  logic             id_branch,
  input  logic             id_taken,
  input  logic [REG_W-1:0] ex_rs,
  input  logic [REG_W-1:0] ex_rt,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_wen,
  input  logic             ex_load,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_wen,
  input  logic             mem_load,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_wen,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic             dec_fwd_a,
  output logic             dec_fwd_b,
  output logic             stall_fetch,
  output logic             stall_decode,
  output logic             bubble_ex,
  output logic             flush_fd
);
  import hz_pkg::*;
  localparam int NOPS = 4;

  logic [REG_W-1:0] op_src [NOPS];
  logic             op_wbe [NOPS];
  logic [1:0]       op_sel [NOPS];
  logic             load_use, br_wait, stall;

  assign op_src[0] = ex_rs;  assign op_wbe[0] = wb_wen;
  assign op_src[1] = ex_rt;  assign op_wbe[1] = wb_wen;
  assign op_src[2] = id_rs;  assign op_wbe[2] = 1'b0;
  assign op_src[3] = id_rt;  assign op_wbe[3] = 1'b0;

  for (genvar g = 0; g < NOPS; g++) begin : g_fwd
    hz_fwd_unit #(.REG_W(REG_W)) u_fwd (
      .src(op_src[g]), .mem_rd(mem_rd), .mem_wen(mem_wen), .mem_load(mem_load),
      .wb_rd(wb_rd), .wb_wen(op_wbe[g]), .sel(op_sel[g])
    );
  end

  hz_stall_unit #(.REG_W(REG_W)) u_stall (
    .slot_mode(slot_mode), .id_rs(id_rs), .id_rt(id_rt),
    .id_rs_used(id_rs_used), .id_rt_used(id_rt_used),
    .id_branch(id_branch), .id_taken(id_taken),
    .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_load(ex_load),
    .mem_rd(mem_rd), .mem_wen(mem_wen), .mem_load(mem_load),
    .load_use(load_use), .br_wait(br_wait), .stall(stall), .flush(flush_fd)
  );

  assign fwd_a        = op_sel[0];
  assign fwd_b        = op_sel[1];
  assign dec_fwd_a    = (op_sel[2] == SRC_MEM);
  assign dec_fwd_b    = (op_sel[3] == SRC_MEM);
  assign stall_fetch  = stall;
  assign stall_decode = stall;
  assign bubble_ex    = stall;
endmodule

// File: rtl/hazard_ctrl_chk.sv
module hazard_ctrl_chk #(
  parameter int REG_W = 5
) (
  input logic             slot_mode,
  input logic [REG_W-1:0] ex_rs,
  input logic [REG_W-1:0] ex_rd,
  input logic             ex_load,
  input logic [REG_W-1:0] mem_rd,
  input logic             mem_wen,
  input logic             mem_load,
  input logic             id_branch,
  input logic [1:0]       fwd_a,
  input logic             stall_fetch,
  input logic             stall_decode,
  input logic             bubble_ex,
  input logic             flush_fd,
  input logic             load_use,
  input logic             br_wait
);
  always_comb begin
    // R1 R11: a memory-stage select needs a non-load writer of that register
    assert_mem_src_R1: assert (fwd_a != 2'b10 || (mem_wen && !mem_load && mem_rd == ex_rs));
    // R4
    assert_zero_reg_R4: assert (ex_rs != '0 || fwd_a == 2'b00);
    // R5: all three hold controls move together
    assert_stall_trio_R5: assert (stall_fetch == stall_decode && stall_decode == bubble_ex);
    // R5: a load-use event must be a load in execute
    assert_load_use_src_R5: assert (!load_use || (ex_load && ex_rd != '0));
    // R7
    assert_branch_wait_R7: assert (!br_wait || id_branch);
    // R9
    assert_no_flush_in_stall_R9: assert (!(flush_fd && stall_decode));
    // R10
    assert_slot_quiet_R10: assert (!slot_mode || !(stall_decode || flush_fd));
  end
endmodule

bind hazard_ctrl hazard_ctrl_chk #(.REG_W(REG_W)) u_chk (
  .slot_mode(slot_mode), .ex_rs(ex_rs), .ex_rd(ex_rd), .ex_load(ex_load),
  .mem_rd(mem_rd), .mem_wen(mem_wen), .mem_load(mem_load), .id_branch(id_branch),
  .fwd_a(fwd_a), .stall_fetch(stall_fetch), .stall_decode(stall_decode),
  .bubble_ex(bubble_ex), .flush_fd(flush_fd), .load_use(load_use), .br_wait(br_wait)
);

// File: tb/tb_hazard_ctrl.sv
module tb_hazard_ctrl;
  localparam int W = 5;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         slot_mode, id_rs_used, id_rt_used, id_branch, id_taken;
  logic         ex_wen, ex_load, mem_wen, mem_load, wb_wen;
  logic [W-1:0] id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd;
  logic [1:0]   fwd_a, fwd_b;
  logic         dec_fwd_a, dec_fwd_b, stall_fetch, stall_decode, bubble_ex, flush_fd;

  int checks = 0, errors = 0;
  bit done = 0;

  hazard_ctrl #(.REG_W(W)) dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // forwarding expectation: 2 = memory, 1 = writeback, 0 = register file
  function automatic int want_src(int s, int mr, bit mw, bit ml, int wr, bit ww);
    int r = 0;
    if (s == 0) return 0;
    if (ww && wr == s) r = 1;
    if (mw && !ml && mr == s) r = 2;
    return r;
  endfunction

  task automatic idle();
    {slot_mode, id_rs_used, id_rt_used, id_branch, id_taken} = '0;
    {ex_wen, ex_load, mem_wen, mem_load, wb_wen} = '0;
    {id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd} = '0;
  endtask

  initial begin
    #1500000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle();
    @(negedge clk);
    chk("R10_idle_stall", int'(stall_decode), 0);
    chk("R9_idle_flush", int'(flush_fd), 0);
    chk("R2_idle_fwd", int'(fwd_a), 0);

    // execute forwarding sweep: R1 R2 R3 R4 R11
    for (int s = 0; s < 4; s++)
      for (int mr = 0; mr < 4; mr++)
        for (int wr = 0; wr < 4; wr++)
          for (int f = 0; f < 8; f++) begin
            idle();
            ex_rs = W'(s); ex_rt = W'((s + 1) % 4);
            mem_rd = W'(mr); wb_rd = W'(wr);
            mem_wen = f[0]; mem_load = f[1]; wb_wen = f[2];
            @(negedge clk);
            chk("R1_R2_R3_R11_fwd_a", int'(fwd_a), want_src(s, mr, f[0], f[1], wr, f[2]));
            chk("R4_fwd_b", int'(fwd_b), want_src((s + 1) % 4, mr, f[0], f[1], wr, f[2]));
          end

    // load-use sweep: R5 R6 R10 R4
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int e = 0; e < 4; e++)
          for (int f = 0; f < 32; f++) begin
            bit hz;
            idle();
            id_rs = W'(a); id_rt = W'(b); ex_rd = W'(e);
            ex_load = f[0]; ex_wen = f[1]; id_rs_used = f[2]; id_rt_used = f[3];
            slot_mode = f[4];
            hz = !f[4] && f[0] && f[1] && e != 0 &&
                 ((f[2] && a == e) || (f[3] && b == e));
            @(negedge clk);
            chk("R5_R6_stall_decode", int'(stall_decode), int'(hz));
            chk("R5_R10_stall_fetch", int'(stall_fetch), int'(hz));
            chk("R5_bubble_ex", int'(bubble_ex), int'(hz));
          end

    // branch sweep: R7 R8 R9 R10
    for (int a = 0; a < 4; a++)
      for (int e = 0; e < 4; e++)
        for (int m = 0; m < 4; m++)
          for (int f = 0; f < 64; f++) begin
            bit st, fl, df;
            idle();
            id_branch = 1'b1; id_rs_used = 1'b1;
            id_rs = W'(a); ex_rd = W'(e); mem_rd = W'(m);
            id_taken = f[0]; ex_wen = f[1]; ex_load = f[2] & f[1];
            mem_wen = f[3]; mem_load = f[4]; slot_mode = f[5];
            st = !f[5] && ((f[1] && e != 0 && a == e) ||
                           (f[3] && f[4] && m != 0 && a == m));
            fl = !f[5] && f[0] && !st;
            df = f[3] && !f[4] && m != 0 && m == a;
            @(negedge clk);
            chk("R7_R10_branch_stall", int'(stall_decode), int'(st));
            chk("R9_R10_flush", int'(flush_fd), int'(fl));
            chk("R8_dec_fwd_a", int'(dec_fwd_a), int'(df));
          end

    // rt-side decode forwarding: R8
    idle();
    id_rt = 5'd7; mem_rd = 5'd7; mem_wen = 1'b1;
    @(negedge clk);
    chk("R8_dec_fwd_b", int'(dec_fwd_b), 1);
    mem_load = 1'b1;
    @(negedge clk);
    chk("R8_dec_fwd_b_load", int'(dec_fwd_b), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule